// File: doc/BRIEF.md
# Clock Generator Power-Down / Power-Up Sequencer

This block controls the orderly shutdown and wake-up of a clock generator. It has an oscillator, a prescaler, a programmable divider, a reference output and a divided output. When power-down is enabled by a mode bit, an active-low pin requests shutdown. The sequencer then takes the outputs down one at a time:

1. It gates the divided output and resets the divider counters.
2. It waits for that output to sit low, then releases its pad driver.
3. It stops the master clock and waits for the reference output to fall, then releases the reference pad.
4. Last, it turns off the oscillator and the external input buffer.

When the pin returns high, the block runs the reverse order:

1. It turns the sources back on.
2. It holds both divider stages at their largest ratio while a settle counter counts a parameterised number of master clock ticks.
3. It restores the programmed ratios.
4. It drives the reference pad, then the divided output pad, and finally releases the output gate.

The sequencer runs on an always-on control clock. Master clock activity arrives as a one-cycle `mclk_tick` pulse, and the asynchronous pin passes through a synchroniser of `SYNC_STAGES` flops. A new power-down request during wake-up turns the sequence around at once. It enters shutdown at the first step that is still safe for whatever is enabled at that moment. The current step is reported on `seq_state` so that the order can be observed.

Top module: `pwrseq_top`

## Requirements
- R1: A synchronous reset puts the sequencer in OFF (code 5) with every control output low. The pin synchroniser resets to the power-down level, so wake-up starts only after the pin has been seen high.
- R2: While `pdn_mode` is 0 the pin is ignored, and the sequencer stays in RUN (code 0).
- R3: A low pin moves the sequencer through RUN(0), GATE(1), OUTZ(2), MCLK(3), REFZ(4) and OFF(5).
  - GATE: `out_en` goes low and `div_rst` goes high.
  - OUTZ: `out_oe` drops.
  - MCLK: `mclk_en` drops.
  - REFZ: `ref_oe` drops.
  - In every shutdown step `osc_en` and `buf_en` stay high.
- R4: GATE is held while `out_lvl` is high. `out_oe` falls only after a cycle in which `out_lvl` was low.
- R5: MCLK is held while `ref_lvl` is high. `ref_oe` falls only after a cycle with `ref_lvl` low, unless `ref_dis` is 1, in which case there is no wait.
- R6: In OFF, `osc_en`, `buf_en` and `div_rst` are low. The oscillator enables fall only after `out_oe`, `ref_oe` and `mclk_en` are already low. OFF is held while the pin is low.
- R7: A high pin moves the sequencer through OFF(5), WAKE(6), SETTLE(7), RESTORE(8), REFON(9), OUTON(10) and back to RUN(0).
  - WAKE: `osc_en`, `buf_en` and `div_rst` are high.
  - SETTLE: `mclk_en` and `div_force_max` are high, and `div_rst` is low.
  - RESTORE: `div_force_max` is low and `div_rst` is high.
  - REFON: `ref_oe` is high.
  - OUTON: `out_oe` is high, with `out_en` low and `div_rst` high.
  - RUN: `out_en` is high and `div_rst` is low.
- R8: `div_force_max` is high only in SETTLE, and both pads are released throughout SETTLE. SETTLE is left on the edge after the `SETTLE_TICKS`-th edge at which the state stayed SETTLE with `mclk_tick` high.
- R9: While `ref_dis` is 1, `ref_oe` stays low in every state.
- R10: A power-down request during wake-up redirects the sequencer as follows:
  - WAKE(6) goes to OFF(5).
  - SETTLE(7) and RESTORE(8) go to REFZ(4).
  - REFON(9) goes to MCLK(3).
  - OUTON(10) goes to GATE(1).
- R11: The settle count restarts from zero each time SETTLE is entered. A full `SETTLE_TICKS` ticks are needed after an interrupted wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_pin_n | input | 1 | Asynchronous power-down request pin, active low |
| pdn_mode | input | 1 | 1 = pin acts as power-down request |
| ref_dis | input | 1 | 1 = reference output pad permanently released |
| mclk_tick | input | 1 | One-cycle pulse per master clock edge |
| out_lvl | input | 1 | Current level of the divided output |
| ref_lvl | input | 1 | Current level of the reference output |
| osc_en | output | 1 | Internal oscillator enable |
| buf_en | output | 1 | External clock input buffer enable |
| mclk_en | output | 1 | Master clock gate enable |
| out_en | output | 1 | Synchronous gate for the divided output |
| out_oe | output | 1 | Divided output pad drive enable (0 = high impedance) |
| div_rst | output | 1 | Divider counter reset |
| div_force_max | output | 1 | Forces prescaler and divider to maximum ratio |
| ref_oe | output | 1 | Reference output pad drive enable (0 = high impedance) |
| seq_state | output | 4 | Encoded sequencer step |

## Verification
The bench builds the block with `SETTLE_TICKS` = 12 and `SYNC_STAGES` = 2. With a settle window this short, the bench can place a power-down request on the exact cycle of SETTLE, RESTORE, REFON or OUTON, and it can pulse the pin for one cycle to hit WAKE. It also varies the tick spacing so the counter is shown to count ticks rather than clock cycles.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_RUN     = 4'd0,
    ST_GATE    = 4'd1,
    ST_OUTZ    = 4'd2,
    ST_MCLK    = 4'd3,
    ST_REFZ    = 4'd4,
    ST_OFF     = 4'd5,
    ST_WAKE    = 4'd6,
    ST_SETTLE  = 4'd7,
    ST_RESTORE = 4'd8,
    ST_REFON   = 4'd9,
    ST_OUTON   = 4'd10
  } seq_state_e;

  typedef struct packed {
    logic out_en;
    logic out_oe;
    logic div_rst;
    logic mclk_en;
    logic ref_oe;
    logic osc_en;
    logic buf_en;
    logic force_max;
  } seq_ctl_t;

  // Control pattern for each step (ref_oe before the disable bit mask).
  function automatic seq_ctl_t ctl_of(seq_state_e s);
    seq_ctl_t c;
    c = '0;
    case (s)
      ST_RUN:     c = '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0};
      ST_GATE:    c = '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0};
      ST_OUTZ:    c = '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0};
      ST_MCLK:    c = '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0};
      ST_REFZ:    c = '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0};
      ST_OFF:     c = '0;
      ST_WAKE:    c = '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0};
      ST_SETTLE:  c = '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1};
      ST_RESTORE: c = '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0};
      ST_REFON:   c = '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0};
      ST_OUTON:   c = '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0};
      default:    c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= RST_VAL;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RST_VAL}};
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/pwrseq_settle.sv
module pwrseq_settle #(
  parameter int TICKS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(TICKS + 1);
  localparam logic [W-1:0] LIMIT = W'(TICKS);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)                cnt <= '0;
    else if (tick && cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pd_req,
  input  logic       out_low,
  input  logic       ref_quiet,
  input  logic       settle_done,
  output seq_state_e state_q,
  output seq_state_e state_d
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (pd_req) state_d = ST_GATE;
      ST_GATE:    if (out_low) state_d = ST_OUTZ;
      ST_OUTZ:    state_d = ST_MCLK;
      ST_MCLK:    if (ref_quiet) state_d = ST_REFZ;
      ST_REFZ:    state_d = ST_OFF;
      ST_OFF:     if (!pd_req) state_d = ST_WAKE;
      ST_WAKE:    state_d = pd_req ? ST_OFF : ST_SETTLE;
      ST_SETTLE: begin
        if (pd_req)           state_d = ST_REFZ;
        else if (settle_done) state_d = ST_RESTORE;
      end
      ST_RESTORE: state_d = pd_req ? ST_REFZ : ST_REFON;
      ST_REFON:   state_d = pd_req ? ST_MCLK : ST_OUTON;
      ST_OUTON:   state_d = pd_req ? ST_GATE : ST_RUN;
      default:    state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/pwrseq_outreg.sv
module pwrseq_outreg
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_d,
  input  logic       ref_dis,
  output seq_ctl_t   ctl_q,
  output logic [3:0] code_q
);
  seq_ctl_t ctl_d;

  always_comb begin
    ctl_d        = ctl_of(state_d);
    ctl_d.ref_oe = ctl_d.ref_oe & ~ref_dis;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      code_q <= ST_OFF;
    end else begin
      ctl_q  <= ctl_d;
      code_q <= state_d;
    end
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int SETTLE_TICKS = 256,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pdn_pin_n,
  input  logic       pdn_mode,
  input  logic       ref_dis,
  input  logic       mclk_tick,
  input  logic       out_lvl,
  input  logic       ref_lvl,
  output logic       osc_en,
  output logic       buf_en,
  output logic       mclk_en,
  output logic       out_en,
  output logic       out_oe,
  output logic       div_rst,
  output logic       div_force_max,
  output logic       ref_oe,
  output logic [3:0] seq_state
);
  logic       pin_s;
  logic       pd_req;
  logic       settle_done;
  seq_state_e st_q, st_d;
  seq_ctl_t   ctl;

  pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d(pdn_pin_n), .q(pin_s)
  );

  assign pd_req = pdn_mode & ~pin_s;

  pwrseq_settle #(.TICKS(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst(rst), .run(st_q == ST_SETTLE),
    .tick(mclk_tick), .done(settle_done)
  );

  pwrseq_fsm u_fsm (
    .clk(clk), .rst(rst), .pd_req(pd_req), .out_low(~out_lvl),
    .ref_quiet(~ref_lvl | ref_dis), .settle_done(settle_done),
    .state_q(st_q), .state_d(st_d)
  );

  pwrseq_outreg u_out (
    .clk(clk), .rst(rst), .state_d(st_d), .ref_dis(ref_dis),
    .ctl_q(ctl), .code_q(seq_state)
  );

  assign osc_en        = ctl.osc_en;
  assign buf_en        = ctl.buf_en;
  assign mclk_en       = ctl.mclk_en;
  assign out_en        = ctl.out_en;
  assign out_oe        = ctl.out_oe;
  assign div_rst       = ctl.div_rst;
  assign div_force_max = ctl.force_max;
  assign ref_oe        = ctl.ref_oe;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pdn_mode,
  input logic       ref_dis,
  input logic       out_lvl,
  input logic       ref_lvl,
  input logic       osc_en,
  input logic       buf_en,
  input logic       mclk_en,
  input logic       out_en,
  input logic       out_oe,
  input logic       div_rst,
  input logic       div_force_max,
  input logic       ref_oe,
  input logic [3:0] seq_state
);
  // R2
  mode_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pdn_mode && seq_state == 4'd0) |=> seq_state == 4'd0);

  // R3
  gate_resets_div_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_en) |-> div_rst);

  // R4
  out_release_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_oe) |-> !$past(out_lvl));

  // R5
  ref_release_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ref_oe) && !$past(ref_dis)) |-> !$past(ref_lvl));

  // R6
  osc_off_last_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_en) |-> (!$past(out_oe) && !$past(ref_oe) && !$past(mclk_en)));

  // R7
  force_after_osc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_force_max) |-> (osc_en && buf_en));

  // R8
  force_pads_off_chk: assert property (@(posedge clk) disable iff (rst)
    div_force_max |-> (!out_oe && !ref_oe));

  // R9
  ref_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_dis && $past(ref_dis)) |-> !ref_oe);
endmodule

bind pwrseq_top pwrseq_chk u_chk (.*);

// File: tb/sim_pwrseq_top.sv
`timescale 1ns/1ps
module sim_pwrseq_top;
  localparam int N    = 12;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdn_pin_n = 1'b1, pdn_mode = 1'b1, ref_dis = 1'b0;
  logic mclk_tick = 1'b0, out_lvl = 1'b0, ref_lvl = 1'b0;
  logic osc_en, buf_en, mclk_en, out_en, out_oe, div_rst, div_force_max, ref_oe;
  logic [3:0] seq_state;

  always #10 clk = ~clk;

  pwrseq_top #(.SETTLE_TICKS(N), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .pdn_pin_n(pdn_pin_n), .pdn_mode(pdn_mode),
    .ref_dis(ref_dis), .mclk_tick(mclk_tick), .out_lvl(out_lvl),
    .ref_lvl(ref_lvl), .osc_en(osc_en), .buf_en(buf_en), .mclk_en(mclk_en),
    .out_en(out_en), .out_oe(out_oe), .div_rst(div_rst),
    .div_force_max(div_force_max), .ref_oe(ref_oe), .seq_state(seq_state)
  );

  int checks = 0, fails = 0;
  int gap = 0, tick_ph = 0;
  logic rd_seen = 1'b0;
  logic [3:0] trace [0:31];
  int trace_n = 0;
  logic [3:0] last_code = 4'd5;
  int settle_cnt = 0;

  // {ref_dis, tick gap[2:0], out high cycles[5:0], ref high cycles[5:0]}
  localparam logic [15:0] VEC [0:5] = '{
    {1'b0, 3'd0, 6'd3,  6'd2},
    {1'b0, 3'd2, 6'd0,  6'd0},
    {1'b0, 3'd1, 6'd7,  6'd5},
    {1'b1, 3'd0, 6'd2,  6'd4},
    {1'b1, 3'd3, 6'd0,  6'd0},
    {1'b0, 3'd4, 6'd10, 6'd1}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Expected controls per step: out_en,out_oe,div_rst,mclk_en,ref_oe,osc_en,buf_en,force
  function automatic logic [7:0] exp_ctl(input logic [3:0] s, input logic rd);
    logic [7:0] e;
    case (s)
      4'd0:  e = 8'b1101_1110;
      4'd1:  e = 8'b0111_1110;
      4'd2:  e = 8'b0011_1110;
      4'd3:  e = 8'b0010_1110;
      4'd4:  e = 8'b0010_0110;
      4'd5:  e = 8'b0000_0000;
      4'd6:  e = 8'b0010_0110;
      4'd7:  e = 8'b0001_0111;
      4'd8:  e = 8'b0011_0110;
      4'd9:  e = 8'b0011_1110;
      4'd10: e = 8'b0111_1110;
      default: e = 8'hxx;
    endcase
    if (rd) e[3] = 1'b0;
    return e;
  endfunction

  always @(posedge clk) rd_seen <= ref_dis;

  initial forever begin
    @(negedge clk); #1;
    tick_ph = (tick_ph >= gap) ? 0 : tick_ph + 1;
    mclk_tick = (tick_ph == 0);
  end

  // Per-cycle monitor: control pattern per step (R3, R6, R7), R9, trace, settle ticks
  initial forever begin
    logic [7:0] act;
    logic [3:0] prev;
    @(negedge clk);
    if (!rst) begin
      act = {out_en, out_oe, div_rst, mclk_en, ref_oe, osc_en, buf_en, div_force_max};
      chk(act === exp_ctl(seq_state, rd_seen), "R3_R6_R7", "controls for step",
          act, exp_ctl(seq_state, rd_seen));
      if (rd_seen) chk(!ref_oe, "R9", "ref_oe while disabled", ref_oe, 0);
      prev = last_code;
      if (seq_state == 4'd7 && prev != 4'd7) settle_cnt = 0;
      else if (seq_state == 4'd7 && prev == 4'd7 && mclk_tick) settle_cnt++;
      if (seq_state != last_code) begin
        if (trace_n < 32) trace[trace_n] = seq_state;
        trace_n++;
        last_code = seq_state;
      end
    end
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic trace_reset();
    trace[0] = seq_state; trace_n = 1; last_code = seq_state;
  endtask

  task automatic wait_code(input logic [3:0] c, input string rq);
    int k = 0;
    while (seq_state != c && k < 3000) begin step(); k++; end
    if (seq_state != c) chk(1'b0, rq, "step not reached", seq_state, c);
  endtask

  task automatic trace_chk(input int n, input logic [63:0] seq, input string rq);
    bit ok = (trace_n == n);
    for (int i = 0; i < n && i < 16; i++)
      if (trace[i] !== seq[63-4*i -: 4]) ok = 1'b0;
    chk(ok, rq, "step order (length)", trace_n, n);
    if (!ok)
      for (int i = 0; i < trace_n && i < 16; i++)
        $display("  step %0d: %0d", i, trace[i]);
  endtask

  task automatic go_off();
    out_lvl = 1'b0; ref_lvl = 1'b0; pdn_pin_n = 1'b0;
    wait_code(4'd5, "R3");
  endtask

  task automatic abort_at(input int k, input int n, input logic [63:0] seq,
                          input string rq);
    go_off();
    step(); trace_reset();
    pdn_pin_n = 1'b1;
    wait_code(4'd7, rq);
    repeat (k) step();
    pdn_pin_n = 1'b0;
    wait_code(4'd5, rq);
    repeat (3) step();
    trace_chk(n, seq, rq);
    pdn_pin_n = 1'b1;
    wait_code(4'd0, rq);
    chk(settle_cnt == N, "R11", "settle ticks after restart", settle_cnt, N);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk(seq_state == 4'd5, "R1", "state in reset", seq_state, 5);
    chk({osc_en, buf_en, mclk_en, out_en, out_oe, div_rst, div_force_max, ref_oe} == 8'h00,
        "R1", "controls in reset",
        {osc_en, buf_en, mclk_en, out_en, out_oe, div_rst, div_force_max, ref_oe}, 0);
    @(negedge clk); rst = 1'b0;
    trace_reset();
    step();
    chk(seq_state == 4'd5, "R1", "held off while synchroniser primes", seq_state, 5);
    wait_code(4'd0, "R7");
    trace_chk(7, 64'h56789A0_000000000, "R7");
    chk(settle_cnt == N, "R8", "settle ticks after reset", settle_cnt, N);

    // Table walk: full shutdown then wake-up
    for (int v = 0; v < 6; v++) begin
      logic [15:0] t = VEC[v];
      int oh = int'(t[11:6]);
      int rh = int'(t[5:0]);
      ref_dis = t[15]; gap = int'(t[14:12]);
      repeat (3) step();
      trace_reset();
      out_lvl = (oh != 0); ref_lvl = (rh != 0);
      pdn_pin_n = 1'b0;
      wait_code(4'd1, "R3");
      repeat (oh) step();
      if (oh != 0) chk(seq_state == 4'd1 && out_oe, "R4", "gate held while out high",
                       seq_state, 1);
      out_lvl = 1'b0;
      wait_code(4'd3, "R3");
      repeat (rh) step();
      if (rh != 0 && !t[15])
        chk(seq_state == 4'd3, "R5", "mclk step held while ref high", seq_state, 3);
      if (rh != 0 && t[15])
        chk(seq_state == 4'd5, "R5", "no ref wait when disabled", seq_state, 5);
      ref_lvl = 1'b0;
      wait_code(4'd5, "R6");
      repeat (6) step();
      chk(seq_state == 4'd5 && !osc_en, "R6", "off held while pin low", seq_state, 5);
      pdn_pin_n = 1'b1;
      wait_code(4'd0, "R7");
      trace_chk(12, 64'h0123456789A0_0000, "R3");
      chk(settle_cnt == N, "R8", "settle ticks with spaced ticks", settle_cnt, N);
      if (t[15]) chk(!ref_oe, "R9", "ref pad released in run", ref_oe, 0);
    end
    ref_dis = 1'b0; gap = 0;
    repeat (3) step();

    // R2: mode bit 0 ignores the pin
    pdn_mode = 1'b0; pdn_pin_n = 1'b0;
    repeat (40) step();
    chk(seq_state == 4'd0 && out_en, "R2", "run with mode off", seq_state, 0);
    pdn_pin_n = 1'b1; repeat (4) step(); pdn_mode = 1'b1;
    repeat (3) step();

    // R10: requests during wake-up
    abort_at(N/2, 5, 64'h56745_00000000000, "R10");
    abort_at(N + 1 + 0 - SYNC, 6, 64'h567845_0000000000, "R10");
    abort_at(N + 1 + 1 - SYNC, 8, 64'h56789345_00000000, "R10");
    abort_at(N + 1 + 2 - SYNC, 11, 64'h56789A12345_00000, "R10");

    // R10: one-cycle pin pulse hits the wake step
    go_off();
    step(); trace_reset();
    pdn_pin_n = 1'b1; step(); pdn_pin_n = 1'b0;
    repeat (8) step();
    trace_chk(3, 64'h565_0000000000000, "R10");
    chk(seq_state == 4'd5 && !osc_en, "R10", "back to off from wake", seq_state, 5);
    pdn_pin_n = 1'b1;
    wait_code(4'd0, "R11");
    chk(settle_cnt == N, "R11", "full settle after wake abort", settle_cnt, N);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule